// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block decides, once per instruction, whether the processor core should leave its current flow and service an interrupt. Five request lines come in, in a fixed polling order: external line 0, timer 0, external line 1, timer 1, and a combined serial line that covers both receive and transmit. A register bus sets a master enable, a per-source enable and a per-source priority bit. When the core signals the end of an instruction, the controller looks at the enabled requests. It picks a winner according to priority level and polling order, and it gives back a one-cycle take pulse, the 16-bit handler address and an acknowledge that clears the winner's request flag.

Two in-service flags, one for each level, track which handlers are running. They enforce the nesting rule. A running low-level handler can be interrupted only by a high-level request. A running high-level handler cannot be interrupted at all. A return strobe from the core closes the highest open level. The core itself and the saving of the program counter lie outside this block.

Top module: `irq_arbiter`

## Requirements
- R1: After reset the take pulse is 0, the acknowledge bus is 0, the vector is 0000h, both registers read back as 00h and no level is in service.
- R2: A write to the enable register (address 10h) stores bit 7 as the master enable and bits 4..0 as per-source enables, bit i for source i in polling order. Bits 6..5 read as 0. A write to the priority register (address 11h) stores bits 4..0, and bits 7..5 read as 0. A write to any other address changes neither register.
- R3: While the master enable is 0, no request is taken, whatever the per-source enables hold.
- R4: A request whose per-source enable bit is 0 is never taken.
- R5: Among candidates at the same level, the lowest-numbered source wins (0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial).
- R6: A candidate whose priority bit is 1 (high) wins over any candidate whose priority bit is 0 (low), regardless of polling order.
- R7: Requests are evaluated only in a cycle where the instruction-boundary strobe is 1. The take output is 1 for exactly the single cycle after that evaluation, and it stays 0 when no boundary strobe arrives.
- R8: When an interrupt is taken, the vector equals 0003h + 8 × source index (0003h, 000Bh, 0013h, 001Bh, 0023h).
- R9: With the take pulse, the acknowledge bus is one-hot on bit i for sources 0 to 3. It stays 0 for the serial source (4) and whenever no interrupt is taken.
- R10: While a low-level handler is in service and no high-level one is, only high-priority candidates can be taken.
- R11: While a high-level handler is in service, nothing is taken.
- R12: A return strobe clears the high in-service flag if it is set, otherwise the low one. A return strobe with no level in service has no effect.
- R13: When a return strobe and a boundary strobe arrive in the same cycle, the evaluation uses the in-service state from before the return. The level that is taken is then marked in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 5 | Request flags, one per source in polling order |
| instr_end | input | 1 | Instruction-boundary strobe; evaluation happens in this cycle |
| reti | input | 1 | Return-from-handler strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read-back of the register at reg_addr (combinational) |
| take | output | 1 | One-cycle pulse: an interrupt was taken |
| vector | output | 16 | Handler address of the last interrupt taken |
| ack | output | 5 | One-cycle acknowledge to the taken source's flag |

## Verification
The bench builds the block with its default parameters: five sources, 8-byte vector spacing and a 16-bit vector. With these values every combination of request pattern and priority pattern (32 × 32) can be swept. So can every combination of per-source enables and requests, with the master enable both on and off. A nested sweep takes a first interrupt and evaluates the same pattern again. It then evaluates once more together with a return strobe, and closes with return strobes. This brings every in-service state and the same-cycle return case within reach, checked against an arithmetic model of the nesting rule.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2
    } lvl_e;

    // Highest level currently open; the one a return closes.
    function automatic lvl_e open_level(input logic hi, input logic lo);
        if (hi)      return LVL_HIGH;
        else if (lo) return LVL_LOW;
        else         return LVL_NONE;
    endfunction

endpackage

// File: rtl/irq_regs.sv
module irq_regs #(
    parameter int                 NUM_SRC  = 5,
    parameter int                 DATA_W   = 8,
    parameter int                 RADDR_W  = 8,
    parameter logic [RADDR_W-1:0] EN_ADDR  = 8'h10,
    parameter logic [RADDR_W-1:0] PRI_ADDR = 8'h11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               master_en,
    output logic [NUM_SRC-1:0] src_en,
    output logic [NUM_SRC-1:0] src_hi
);

    localparam int MASTER_BIT = DATA_W - 1;

    typedef struct packed {
        logic               master;
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] hi;
    } regs_t;

    regs_t r_d, r_q;

    logic unused_wbits;
    assign unused_wbits = ^reg_wdata[MASTER_BIT-1:NUM_SRC];

    always_comb begin
        r_d = r_q;
        if (reg_we && reg_addr == EN_ADDR) begin
            r_d.master = reg_wdata[MASTER_BIT];
            r_d.en     = reg_wdata[NUM_SRC-1:0];
        end
        if (reg_we && reg_addr == PRI_ADDR) begin
            r_d.hi = reg_wdata[NUM_SRC-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == EN_ADDR) begin
            reg_rdata[NUM_SRC-1:0] = r_q.en;
            reg_rdata[MASTER_BIT]  = r_q.master;
        end else if (reg_addr == PRI_ADDR) begin
            reg_rdata[NUM_SRC-1:0] = r_q.hi;
        end
    end

    assign master_en = r_q.master;
    assign src_en    = r_q.en;
    assign src_hi    = r_q.hi;

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NUM_SRC = 5,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] cand,
    output logic               any,
    output logic [NUM_SRC-1:0] winner,
    output logic [IDX_W-1:0]   idx
);

    // Fixed polling order: lower index is polled first.
    genvar i;
    generate
        for (i = 0; i < NUM_SRC; i++) begin : g_chain
            if (i == 0) begin : g_first
                assign winner[i] = cand[i];
            end else begin : g_rest
                assign winner[i] = cand[i] & ~(|cand[i-1:0]);
            end
        end
    endgenerate

    assign any = |cand;

    always_comb begin
        idx = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (winner[k]) idx = idx | IDX_W'(k);
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int                 NUM_SRC   = 5,
    parameter int                 DATA_W    = 8,
    parameter int                 RADDR_W   = 8,
    parameter logic [RADDR_W-1:0] EN_ADDR   = 8'h10,
    parameter logic [RADDR_W-1:0] PRI_ADDR  = 8'h11,
    parameter int                 VEC_W     = 16,
    parameter int                 VEC_BASE  = 3,
    parameter int                 VEC_SHIFT = 3,
    parameter logic [NUM_SRC-1:0] ACK_MASK  = 5'b01111
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               instr_end,
    input  logic               reti,
    input  logic               reg_we,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               take,
    output logic [VEC_W-1:0]   vector,
    output logic [NUM_SRC-1:0] ack
);

    import irq_pkg::*;

    localparam int               IDX_W  = $clog2(NUM_SRC);
    localparam logic [VEC_W-1:0] BASE_V = VEC_W'(VEC_BASE);

    typedef struct packed {
        logic               ins_hi;
        logic               ins_lo;
        logic               take;
        logic [VEC_W-1:0]   vec;
        logic [NUM_SRC-1:0] ack;
    } st_t;

    st_t st_d, st_q;

    logic               master_en;
    logic [NUM_SRC-1:0] src_en;
    logic [NUM_SRC-1:0] src_hi;
    logic [NUM_SRC-1:0] cand, cand_hi, cand_lo;
    logic               any_hi, any_lo;
    logic [NUM_SRC-1:0] win_hi, win_lo;
    logic [IDX_W-1:0]   idx_hi, idx_lo;
    logic               ins_hi_w, ins_lo_w;

    irq_regs #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W),
        .RADDR_W (RADDR_W),
        .EN_ADDR (EN_ADDR),
        .PRI_ADDR(PRI_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .master_en(master_en),
        .src_en   (src_en),
        .src_hi   (src_hi)
    );

    assign cand    = irq_req & src_en & {NUM_SRC{master_en}};
    assign cand_hi = cand & src_hi;
    assign cand_lo = cand & ~src_hi;

    irq_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick_hi (
        .cand  (cand_hi),
        .any   (any_hi),
        .winner(win_hi),
        .idx   (idx_hi)
    );

    irq_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick_lo (
        .cand  (cand_lo),
        .any   (any_lo),
        .winner(win_lo),
        .idx   (idx_lo)
    );

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;
        st_d.ack  = '0;

        // Return closes the highest open level.
        if (reti) begin
            case (open_level(st_q.ins_hi, st_q.ins_lo))
                LVL_HIGH: st_d.ins_hi = 1'b0;
                LVL_LOW:  st_d.ins_lo = 1'b0;
                default:  ;
            endcase
        end

        // Evaluation looks at the in-service state before this cycle's return.
        if (instr_end && !st_q.ins_hi) begin
            if (any_hi) begin
                st_d.take   = 1'b1;
                st_d.ins_hi = 1'b1;
                st_d.vec    = BASE_V + (VEC_W'(idx_hi) << VEC_SHIFT);
                st_d.ack    = win_hi & ACK_MASK;
            end else if (any_lo && !st_q.ins_lo) begin
                st_d.take   = 1'b1;
                st_d.ins_lo = 1'b1;
                st_d.vec    = BASE_V + (VEC_W'(idx_lo) << VEC_SHIFT);
                st_d.ack    = win_lo & ACK_MASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take     = st_q.take;
    assign vector   = st_q.vec;
    assign ack      = st_q.ack;
    assign ins_hi_w = st_q.ins_hi;
    assign ins_lo_w = st_q.ins_lo;

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
    parameter int                 NUM_SRC   = 5,
    parameter int                 VEC_W     = 16,
    parameter int                 VEC_BASE  = 3,
    parameter int                 VEC_SHIFT = 3,
    parameter logic [NUM_SRC-1:0] ACK_MASK  = 5'b01111
) (
    input logic               clk,
    input logic               rst_n,
    input logic               instr_end,
    input logic               master_en,
    input logic               ins_hi,
    input logic               ins_lo,
    input logic               take,
    input logic [VEC_W-1:0]   vector,
    input logic [NUM_SRC-1:0] ack
);

    localparam logic [VEC_SHIFT-1:0] LOW_BITS = VEC_SHIFT'(VEC_BASE);

    a_r7_take_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(instr_end));

    a_r3_take_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(master_en));

    a_r11_high_not_preempted: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !$past(ins_hi));

    a_r10_low_open_only_high: assert property (@(posedge clk) disable iff (!rst_n)
        (take && $past(ins_lo)) |-> ins_hi);

    a_r8_vector_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (vector[VEC_SHIFT-1:0] == LOW_BITS));

    a_r9_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack));

    a_r9_ack_with_take: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack) |-> take);

    a_r9_serial_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack & ~ACK_MASK) == '0);

endmodule

bind irq_arbiter irq_arbiter_chk #(
    .NUM_SRC  (NUM_SRC),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_SHIFT(VEC_SHIFT),
    .ACK_MASK (ACK_MASK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .instr_end(instr_end),
    .master_en(master_en),
    .ins_hi   (ins_hi_w),
    .ins_lo   (ins_lo_w),
    .take     (take),
    .vector   (vector),
    .ack      (ack)
);

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  irq_req = '0;
    logic        instr_end = 1'b0;
    logic        reti = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        take;
    logic [15:0] vector;
    logic [4:0]  ack;

    int  total = 0;
    int  bad = 0;
    bit  done = 0;

    // bench model state
    bit       m_master;
    bit [4:0] m_en, m_pri;
    bit       m_hi, m_lo;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .instr_end(instr_end),
        .reti(reti), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .take(take), .vector(vector), .ack(ack)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a == 8'h10) begin m_master = d[7]; m_en = d[4:0]; end
        if (a == 8'h11) m_pri = d[4:0];
    endtask

    task automatic ret();
        @(negedge clk);
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
        if (m_hi) m_hi = 0; else m_lo = 0;
    endtask

    // One evaluation at an instruction boundary, optionally with a return.
    task automatic evaluate(input bit with_reti, input string tag);
        bit [4:0]  cand;
        int        win;
        bit        win_hi;
        bit        e_take;
        bit [15:0] e_vec;
        bit [4:0]  e_ack;
        cand   = irq_req & m_en & {5{m_master}};
        win    = -1;
        win_hi = 0;
        if (!m_hi) begin
            for (int k = 4; k >= 0; k--)
                if (cand[k] && m_pri[k]) begin win = k; win_hi = 1; end
            if (win < 0 && !m_lo)
                for (int k = 4; k >= 0; k--)
                    if (cand[k] && !m_pri[k]) win = k;
        end
        e_take = (win >= 0);
        e_vec  = e_take ? 16'(3 + 8 * win) : vector;
        e_ack  = (e_take && win < 4) ? 5'(1 << win) : 5'd0;
        @(negedge clk);
        instr_end = 1'b1; reti = with_reti;
        @(negedge clk);
        instr_end = 1'b0; reti = 1'b0;
        if (with_reti) begin
            if (m_hi) m_hi = 0; else m_lo = 0;
        end
        if (e_take) begin
            if (win_hi) m_hi = 1; else m_lo = 1;
        end
        check(take == e_take && vector == e_vec && ack == e_ack, tag,
              {take, 6'd0, ack, vector}, {e_take, 6'd0, e_ack, e_vec});
        @(negedge clk);
        check(take == 1'b0 && ack == 5'd0, "R7 pulse width", {take, ack}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_master = 0; m_en = 0; m_pri = 0; m_hi = 0; m_lo = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(take == 0 && ack == 0 && vector == 0, "R1 outputs", {take, ack, vector}, 0);
        reg_addr = 8'h10; #1;
        check(reg_rdata == 0, "R1 enable reg", reg_rdata, 0);
        reg_addr = 8'h11; #1;
        check(reg_rdata == 0, "R1 priority reg", reg_rdata, 0);

        // R2: register fields and readback
        wr(8'h10, 8'hFF);
        reg_addr = 8'h10; #1;
        check(reg_rdata == 8'h9F, "R2 enable readback", reg_rdata, 8'h9F);
        wr(8'h11, 8'hFF);
        reg_addr = 8'h11; #1;
        check(reg_rdata == 8'h1F, "R2 priority readback", reg_rdata, 8'h1F);
        wr(8'h12, 8'h00);
        reg_addr = 8'h10; #1;
        check(reg_rdata == 8'h9F, "R2 other address enable", reg_rdata, 8'h9F);
        reg_addr = 8'h11; #1;
        check(reg_rdata == 8'h1F, "R2 other address priority", reg_rdata, 8'h1F);
        wr(8'h10, 8'h0A);
        reg_addr = 8'h10; #1;
        check(reg_rdata == 8'h0A, "R2 master clear", reg_rdata, 8'h0A);

        // R1: reset also leaves nothing in service (R11 path open)
        wr(8'h10, 8'h9F);
        wr(8'h11, 8'h00);

        // R7: no boundary strobe, no take
        irq_req = 5'h1F;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            check(take == 0, "R7 no boundary", take, 0);
        end

        // R5 R6 R8 R9: priority x request sweep, all enabled
        for (int p = 0; p < 32; p++) begin
            wr(8'h11, 8'(p));
            for (int r = 0; r < 32; r++) begin
                irq_req = 5'(r);
                evaluate(0, "R5 R6 R8 R9 sweep");
                ret(); ret();
            end
        end

        // R3 R4: enable sweep with master on and off
        wr(8'h11, 8'h00);
        for (int m = 0; m < 2; m++) begin
            for (int e = 0; e < 32; e++) begin
                wr(8'h10, 8'((m << 7) | e));
                for (int r = 0; r < 32; r++) begin
                    irq_req = 5'(r);
                    evaluate(0, m ? "R4 source enable" : "R3 master off");
                    ret(); ret();
                end
            end
        end

        // R10 R11 R12 R13: nesting sweep
        wr(8'h10, 8'h9F);
        for (int p = 0; p < 32; p++) begin
            wr(8'h11, 8'(p));
            for (int r = 1; r < 32; r++) begin
                irq_req = 5'(r);
                evaluate(0, "R10 R11 first take");
                evaluate(0, "R10 R11 nested");
                evaluate(1, "R13 return with boundary");
                ret();
                evaluate(0, "R12 after one return");
                ret(); ret(); ret();
                irq_req = 5'd0;
                evaluate(0, "R12 idle return");
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule